// File: doc/BRIEF.md
# MDIO Management Register Responder

This block is the management end of a clause-22 style serial management link. It watches a slow management clock and a bidirectional data line, both sampled from the fast system clock, and decodes each frame: a run of at least 32 ones, a two-bit start pattern, an operation code, a PHY address, a register number, a turnaround and sixteen data bits. When the address in the frame matches the configured PHY address, a write frame updates one word of a small register file. A read frame causes the block to take over the line and shift the addressed word back, most significant bit first.

Three of the readable words are not stored. The basic status word reports fixed speed and duplex abilities, a completed negotiation and the live link input. The link-partner word echoes the advertised abilities. A diagnostic word reports the chosen speed and duplex, taken from the best mode currently advertised. Negotiation therefore always succeeds with whatever the advertisement word holds.

Top module: `mdio_phy_resp`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones sampled on rising MDC edges; a zero seen before 32 ones restarts the count, and the first zero after 32 or more ones is the first start bit.
- R2: The start pattern is 0 then 1; if the second start bit is 0 the frame is abandoned, no write takes place and the line is not driven.
- R3: After the start bits the fields arrive as 2-bit opcode, 5-bit PHY address (MSB first), 5-bit register number (MSB first), 2 turnaround bits and 16 data bits (MSB first); opcode 10 is a read, 01 a write, and 00 or 11 abandon the frame with no write and no drive.
- R4: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400, register 4 reads 0x01E1, and other stored registers read 0x0000.
- R5: Register 1 reads 0x7828 with bit 2 equal to the link_up input (0x782C when link_up is 1).
- R6: Register 5 reads 0x4000 OR (register 4 AND 0x01E0).
- R7: Register 18 reads with bit 10 = register 4 bit 7 OR bit 8, bit 11 = register 4 bit 8 OR bit 6, and all other bits 0.
- R8: A write frame whose PHY address equals phy_addr stores the 16 data bits into the addressed register, later read back unchanged for registers other than 1, 5 and 18; a frame with a different PHY address changes no register and never drives the line.
- R9: For a matching read, mdio_oe is high for exactly 17 bit slots: the second turnaround slot, which carries 0, and the 16 data slots, carrying the register MSB first; mdio_oe and mdio_out change only just after a rising MDC edge.
- R10: After the last data bit the block returns to preamble hunting, so a frame that follows without a fresh 32-one preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples MDC and MDIO |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Management data line as seen at the pin |
| link_up | input | 1 | Link state reported in the status register |
| phy_addr | input | 5 | Address this responder answers to |
| mdio_out | output | 1 | Data value driven onto the line during reads |
| mdio_oe | output | 1 | High while the responder drives the line |

## Verification
The assertions take for granted that MDC is slow against clk, with each MDC level held for several system clocks, that MDIO is stable around each rising MDC edge, and that phy_addr stays constant through a frame; the output-timing and drive-ownership properties depend on these. The bench holds each MDC half period for six system clocks, changes MDIO only while MDC is low, and sets phy_addr only between frames. It also releases the line to 1 during a read's turnaround and data field, as a pulled-up bus would appear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_OPCODE,
    ST_PHYAD,
    ST_REGAD,
    ST_TURN,
    ST_DATA
  } mdio_state_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam int REG_CTRL    = 0;
  localparam int REG_STATUS  = 1;
  localparam int REG_ID_HI   = 2;
  localparam int REG_ID_LO   = 3;
  localparam int REG_ADV     = 4;
  localparam int REG_PARTNER = 5;
  localparam int REG_DIAG    = 18;

  localparam logic [15:0] RST_CTRL  = 16'h3100;
  localparam logic [15:0] RST_ID_HI = 16'h0300;
  localparam logic [15:0] RST_ID_LO = 16'hE400;
  localparam logic [15:0] RST_ADV   = 16'h01E1;

  localparam logic [15:0] STATUS_FIXED = 16'h7828;
  localparam logic [15:0] PARTNER_ACK  = 16'h4000;
  localparam logic [15:0] ADV_ABIL_MSK = 16'h01E0;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc,
  input  logic mdio_in,
  output logic bit_rise,
  output logic bit_val
);

  logic [STAGES-1:0] mdc_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              mdc_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            mdc_pipe[0] <= 1'b0;
            dat_pipe[0] <= 1'b1;
          end else begin
            mdc_pipe[0] <= mdc;
            dat_pipe[0] <= mdio_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            mdc_pipe[g] <= 1'b0;
            dat_pipe[g] <= 1'b1;
          end else begin
            mdc_pipe[g] <= mdc_pipe[g-1];
            dat_pipe[g] <= dat_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_prev <= 1'b0;
      bit_rise <= 1'b0;
      bit_val  <= 1'b1;
    end else begin
      mdc_prev <= mdc_pipe[STAGES-1];
      bit_rise <= mdc_pipe[STAGES-1] & ~mdc_prev;
      bit_val  <= dat_pipe[STAGES-1];
    end
  end

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_up,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] adv;
  logic [DW-1:0] status_w;
  logic [DW-1:0] partner_w;
  logic [DW-1:0] diag_w;
  logic [DW-1:0] lookup;

  function automatic logic [DW-1:0] init_word(input int idx);
    case (idx)
      REG_CTRL:  return DW'(RST_CTRL);
      REG_ID_HI: return DW'(RST_ID_HI);
      REG_ID_LO: return DW'(RST_ID_LO);
      REG_ADV:   return DW'(RST_ADV);
      default:   return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= init_word(i);
      end
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign adv = mem[REG_ADV];

  always_comb begin
    status_w    = DW'(STATUS_FIXED);
    status_w[2] = link_up;
    partner_w   = DW'(PARTNER_ACK) | (adv & DW'(ADV_ABIL_MSK));
    diag_w      = '0;
    diag_w[10]  = adv[7] | adv[8];
    diag_w[11]  = adv[8] | adv[6];
  end

  always_comb begin
    case (int'(rd_addr))
      REG_STATUS:  lookup = status_w;
      REG_PARTNER: lookup = partner_w;
      REG_DIAG:    lookup = diag_w;
      default:     lookup = mem[rd_addr];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= lookup;
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PA_W    = 5,
  parameter int RA_W    = 5,
  parameter int DW      = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_rise,
  input  logic            bit_val,
  input  logic [PA_W-1:0] phy_addr,
  input  logic [DW-1:0]   rd_data,
  output logic [RA_W-1:0] reg_addr,
  output logic            wr_en,
  output logic [DW-1:0]   wr_data,
  output logic            mdio_out,
  output logic            mdio_oe,
  output logic            is_read,
  output logic            addr_match,
  output logic            idle
);

  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int MAXF = (DW > PA_W) ? ((DW > RA_W) ? DW : RA_W) : ((PA_W > RA_W) ? PA_W : RA_W);
  localparam int CW  = $clog2(MAXF);

  mdio_state_t     state;
  logic [PCW-1:0]  pre_cnt;
  logic [CW-1:0]   cnt;
  logic [1:0]      opc;
  logic [PA_W-1:0] pa_sh;
  logic [RA_W-1:0] ra_sh;
  logic [DW-1:0]   dat_sh;
  logic [1:0]      opc_next;
  logic            drive;

  assign opc_next   = {opc[0], bit_val};
  assign is_read    = (opc == OPC_READ);
  assign addr_match = (pa_sh == phy_addr);
  assign drive      = is_read & addr_match;
  assign reg_addr   = ra_sh;
  assign idle       = (state == ST_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      pre_cnt  <= '0;
      cnt      <= '0;
      opc      <= '0;
      pa_sh    <= '0;
      ra_sh    <= '0;
      dat_sh   <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bit_rise) begin
        case (state)
          ST_HUNT: begin
            if (bit_val) begin
              if (pre_cnt != PCW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
            end else if (pre_cnt == PCW'(PRE_LEN)) begin
              pre_cnt <= '0;
              state   <= ST_START;
            end else begin
              pre_cnt <= '0;
            end
          end
          ST_START: begin
            cnt   <= '0;
            state <= bit_val ? ST_OPCODE : ST_HUNT;
          end
          ST_OPCODE: begin
            opc <= opc_next;
            if (cnt == CW'(1)) begin
              cnt <= '0;
              if (opc_next == OPC_READ || opc_next == OPC_WRITE) state <= ST_PHYAD;
              else                                               state <= ST_HUNT;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PHYAD: begin
            pa_sh <= {pa_sh[PA_W-2:0], bit_val};
            if (cnt == CW'(PA_W - 1)) begin
              cnt   <= '0;
              state <= ST_REGAD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_REGAD: begin
            ra_sh <= {ra_sh[RA_W-2:0], bit_val};
            if (cnt == CW'(RA_W - 1)) begin
              cnt   <= '0;
              state <= ST_TURN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TURN: begin
            if (cnt == '0) begin
              cnt <= CW'(1);
              if (drive) begin
                mdio_oe  <= 1'b1;
                mdio_out <= 1'b0;
                dat_sh   <= rd_data;
              end
            end else begin
              cnt   <= '0;
              state <= ST_DATA;
              if (drive) begin
                mdio_out <= dat_sh[DW-1];
                dat_sh   <= {dat_sh[DW-2:0], 1'b0};
              end
            end
          end
          ST_DATA: begin
            if (drive) begin
              if (cnt == CW'(DW - 1)) begin
                mdio_oe  <= 1'b0;
                mdio_out <= 1'b0;
              end else begin
                mdio_out <= dat_sh[DW-1];
                dat_sh   <= {dat_sh[DW-2:0], 1'b0};
              end
            end else begin
              dat_sh <= {dat_sh[DW-2:0], bit_val};
            end
            if (cnt == CW'(DW - 1)) begin
              cnt     <= '0;
              pre_cnt <= '0;
              state   <= ST_HUNT;
              if (!is_read && addr_match) begin
                wr_en   <= 1'b1;
                wr_data <= {dat_sh[DW-2:0], bit_val};
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/mdio_phy_resp.sv
module mdio_phy_resp #(
  parameter int PRE_LEN     = 32,
  parameter int PA_W        = 5,
  parameter int RA_W        = 5,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mdc,
  input  logic            mdio_in,
  input  logic            link_up,
  input  logic [PA_W-1:0] phy_addr,
  output logic            mdio_out,
  output logic            mdio_oe
);

  logic            mdc_rise;
  logic            mdio_bit;
  logic [RA_W-1:0] reg_addr;
  logic            wr_en;
  logic [DW-1:0]   wr_data;
  logic [DW-1:0]   rd_data;
  logic            fr_is_read;
  logic            fr_match;
  logic            fr_idle;

  mdio_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .bit_rise (mdc_rise),
    .bit_val  (mdio_bit)
  );

  mdio_frame #(
    .PRE_LEN (PRE_LEN),
    .PA_W    (PA_W),
    .RA_W    (RA_W),
    .DW      (DW)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .bit_rise   (mdc_rise),
    .bit_val    (mdio_bit),
    .phy_addr   (phy_addr),
    .rd_data    (rd_data),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .is_read    (fr_is_read),
    .addr_match (fr_match),
    .idle       (fr_idle)
  );

  mdio_regfile #(
    .AW (RA_W),
    .DW (DW)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .wr_en   (wr_en),
    .wr_addr (reg_addr),
    .wr_data (wr_data),
    .rd_addr (reg_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/mdio_phy_resp_chk.sv
module mdio_phy_resp_chk (
  input logic clk,
  input logic rst,
  input logic mdc_rise,
  input logic mdio_out,
  input logic mdio_oe,
  input logic wr_en,
  input logic fr_is_read,
  input logic fr_match,
  input logic fr_idle
);

  // R9: drive enable moves only in the cycle after a detected MDC rise
  a_r9_oe_after_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_oe) |-> $past(mdc_rise));

  // R9: driven data moves only in the cycle after a detected MDC rise
  a_r9_out_after_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_out) |-> $past(mdc_rise));

  // R8: line is only taken for a read addressed to this responder
  a_r8_drive_owned: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (fr_is_read && fr_match));

  // R8: a register update never coincides with driving the line
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !mdio_oe);

  // R10: releasing the line coincides with the return to preamble hunting
  a_r10_release_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(mdio_oe) |-> fr_idle);

endmodule

bind mdio_phy_resp mdio_phy_resp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .mdc_rise   (mdc_rise),
  .mdio_out   (mdio_out),
  .mdio_oe    (mdio_oe),
  .wr_en      (wr_en),
  .fr_is_read (fr_is_read),
  .fr_match   (fr_match),
  .fr_idle    (fr_idle)
);

// File: tb/mdio_phy_resp_tb.sv
module mdio_phy_resp_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mdc = 1'b0;
  logic       mdio_in = 1'b1;
  logic       link_up = 1'b1;
  logic [4:0] phy_addr = 5'd1;
  logic       mdio_out;
  logic       mdio_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mdio_phy_resp u_dut (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .link_up  (link_up),
    .phy_addr (phy_addr),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe)
  );

  // {write, reg[4:0], wdata[15:0], expected[15:0]}
  localparam int NV = 20;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 5'd0,  16'h0000, 16'h3100}, // R4
    {1'b0, 5'd2,  16'h0000, 16'h0300}, // R4
    {1'b0, 5'd3,  16'h0000, 16'hE400}, // R4
    {1'b0, 5'd4,  16'h0000, 16'h01E1}, // R4
    {1'b0, 5'd1,  16'h0000, 16'h782C}, // R5
    {1'b0, 5'd5,  16'h0000, 16'h41E0}, // R6
    {1'b0, 5'd18, 16'h0000, 16'h0C00}, // R7
    {1'b0, 5'd7,  16'h0000, 16'h0000}, // R4
    {1'b1, 5'd7,  16'hA5C3, 16'h0000}, // R8
    {1'b0, 5'd7,  16'h0000, 16'hA5C3}, // R8
    {1'b1, 5'd4,  16'h0061, 16'h0000}, // R8
    {1'b0, 5'd5,  16'h0000, 16'h4060}, // R6
    {1'b0, 5'd18, 16'h0000, 16'h0800}, // R7
    {1'b1, 5'd4,  16'h0081, 16'h0000}, // R8
    {1'b0, 5'd18, 16'h0000, 16'h0400}, // R7
    {1'b0, 5'd5,  16'h0000, 16'h4080}, // R6
    {1'b1, 5'd0,  16'h1234, 16'h0000}, // R8
    {1'b0, 5'd0,  16'h0000, 16'h1234}, // R8
    {1'b1, 5'd31, 16'h8001, 16'h0000}, // R8
    {1'b0, 5'd31, 16'h0000, 16'h8001}  // R8
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half_slot();
    repeat (6) @(negedge clk);
  endtask

  // One frame: npre preamble ones, then start, opcode, addresses, turnaround, data.
  task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output int oe_n, output logic ta_zero);
    logic [31:0] bits;
    logic        rel;
    rd = '0;
    oe_n = 0;
    ta_zero = 1'b1;
    rel = (op == 2'b10);
    bits = {st, op, pa, ra, (rel ? 2'b11 : 2'b10), (rel ? 16'hFFFF : wd)};
    for (int p = 0; p < npre; p++) begin
      mdio_in = 1'b1;
      half_slot();
      mdc = 1'b1;
      half_slot();
      mdc = 1'b0;
    end
    for (int i = 31; i >= 0; i--) begin
      mdio_in = bits[i];
      half_slot();
      if (mdio_oe) begin
        oe_n++;
        if (i == 16 && mdio_out) ta_zero = 1'b0;
        if (i < 16) rd[i] = mdio_out;
      end
      mdc = 1'b1;
      half_slot();
      mdc = 1'b0;
    end
    mdio_in = 1'b1;
    half_slot();
  endtask

  task automatic do_read(input string tag, input logic [4:0] ra, input logic [15:0] exp);
    logic [15:0] rd;
    int          n;
    logic        tz;
    frame(32, 2'b01, 2'b10, phy_addr, ra, 16'h0, rd, n, tz);
    check(tag, rd, exp);
    check({tag, " R9 drive slots"}, 16'(n), 16'd17);
    check({tag, " R9 turnaround zero"}, 16'(tz), 16'd1);
  endtask

  task automatic do_write(input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd;
    int          n;
    logic        tz;
    frame(32, 2'b01, 2'b01, phy_addr, ra, wd, rd, n, tz);
    check("R8 no drive during write", 16'(n), 16'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    int          n;
    logic        tz;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset oe low", 16'(mdio_oe), 16'd0);
    check("R9 reset out low", 16'(mdio_out), 16'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][37]) do_write(VEC[v][36:32], VEC[v][31:16]);
      else            do_read($sformatf("vector %0d", v), VEC[v][36:32], VEC[v][15:0]);
    end

    // R5: link input visible in the status word
    link_up = 1'b0;
    do_read("R5 link down", 5'd1, 16'h7828);
    link_up = 1'b1;

    // R8: other PHY address, read not driven and write ignored
    frame(32, 2'b01, 2'b10, 5'd2, 5'd7, 16'h0, rd, n, tz);
    check("R8 mismatch read no drive", 16'(n), 16'd0);
    frame(32, 2'b01, 2'b01, 5'd9, 5'd7, 16'h1111, rd, n, tz);
    do_read("R8 mismatch write ignored", 5'd7, 16'hA5C3);

    // R1: 31 ones are not enough
    frame(31, 2'b01, 2'b01, phy_addr, 5'd7, 16'h2222, rd, n, tz);
    do_read("R1 short preamble write ignored", 5'd7, 16'hA5C3);
    frame(31, 2'b01, 2'b10, phy_addr, 5'd7, 16'h0, rd, n, tz);
    check("R1 short preamble read no drive", 16'(n), 16'd0);

    // R2: bad start pattern
    frame(32, 2'b00, 2'b01, phy_addr, 5'd7, 16'h2424, rd, n, tz);
    do_read("R2 bad start write ignored", 5'd7, 16'hA5C3);

    // R3: reserved opcodes
    frame(32, 2'b01, 2'b11, phy_addr, 5'd7, 16'h3636, rd, n, tz);
    check("R3 opcode 11 no drive", 16'(n), 16'd0);
    frame(32, 2'b01, 2'b00, phy_addr, 5'd7, 16'h3636, rd, n, tz);
    do_read("R3 reserved opcodes ignored", 5'd7, 16'hA5C3);

    // R10: back-to-back frame without new preamble is ignored
    do_write(5'd7, 16'h3333);
    frame(0, 2'b01, 2'b01, phy_addr, 5'd7, 16'h4444, rd, n, tz);
    do_read("R10 no-preamble frame ignored", 5'd7, 16'h3333);

    // R8: other configured address
    phy_addr = 5'd30;
    repeat (4) @(negedge clk);
    do_read("R8 address 30", 5'd0, 16'h1234);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule